// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between a clock synthesizer and the output pads and decides, cycle by cycle, which copies of two source clocks reach the board. A fast processor-class clock feeds a bank of gated copies, and a slower free-running bus-class clock feeds a bank of stoppable copies plus one copy that keeps running when the bus stop is requested. Three active-low requests control the bank: a processor stop, a bus stop and a global power-down. Each output also has its own enable bit. A three-state request removes the drive from every pad.

Each request passes through a two-flop synchronizer in the domain of the clock it acts on. The gating enable of every output is a flop clocked on the falling edge of its source clock, and the output is the plain AND of the source clock and that flop. An enable can therefore only change while the source clock is low. A stopped output finishes the high phase it has begun, then stays low. A restarted output begins with a complete high phase. Stopped and disabled outputs keep their pad drive on and are held at logic low. Only the three-state request turns the pad enables off.

Reset is synchronous and active high, sampled in both clock domains. After reset every enable is active and no stop is pending.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset is released with all requests idle (`cpu_stop_n`, `pci_stop_n`, `pd_n` high, `hiz_req` low) and all enable bits set, every gated output toggles once per source-clock cycle and every pad enable is 1.
- R2: When `cpu_stop_n` is low at a rising edge k of `clk_cpu`, each processor output still gives exactly the pulses of edges k and k+1, then stays at logic 0.
- R3: When `cpu_stop_n` returns high at rising edge k of `clk_cpu`, the processor outputs give no pulse at edges k and k+1, and their first pulse is a complete high phase at edge k+2.
- R4: `pci_stop_n` is sampled on rising edges of `clk_pci` and uses the same two-edge stop and restart latency on the stoppable bus outputs. `pcif_clk_o` ignores `pci_stop_n` and keeps toggling.
- R5: While `pd_n` is low, every output (processor, stoppable bus and free-running bus) stops after its two remaining full pulses and is held at 0 with its pad enable still 1. When `pd_n` returns high, the outputs restart with the R3 latency.
- R6: Bit i of `cpu_en` gates `cpu_clk_o[i]`, and bit i of `pci_en` gates `pci_clk_o[i]` (1 = run, 0 = held low). `pcif_en` gates `pcif_clk_o`. Clearing one bit stops only that output, with the R2 latency, and keeps its pad enable at 1. The other outputs keep toggling.
- R7: `hiz_req` high clears every pad enable two rising edges of the domain clock after it is sampled. Going low again restores the pad enables with the same latency.
- R8: Every high pulse on a gated output lasts exactly one full high phase of its source clock. No gating enable changes while its source clock is high.
- R9: A processor stop leaves the bus outputs unaffected, and a bus stop leaves the processor outputs unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor-class source clock |
| clk_pci | input | 1 | Free-running bus-class source clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| cpu_stop_n | input | 1 | Processor outputs stop request, active low |
| pci_stop_n | input | 1 | Stoppable bus outputs stop request, active low |
| pd_n | input | 1 | Power-down request for all outputs, active low |
| hiz_req | input | 1 | Three-state request for all pads, active high |
| cpu_en | input | N_CPU | Per-output run enable for the processor outputs |
| pci_en | input | N_PCI | Per-output run enable for the stoppable bus outputs |
| pcif_en | input | 1 | Run enable for the free-running bus output |
| cpu_clk_o | output | N_CPU | Gated processor clock copies |
| cpu_oe_o | output | N_CPU | Pad drive enables of the processor copies |
| pci_clk_o | output | N_PCI | Gated stoppable bus clock copies |
| pci_oe_o | output | N_PCI | Pad drive enables of the stoppable bus copies |
| pcif_clk_o | output | 1 | Free-running bus clock copy |
| pcif_oe_o | output | 1 | Pad drive enable of the free-running copy |

## Verification
The hardest situation to reach is one where the two clock domains respond to a shared request at different phases. Power-down and three-state act on both banks, each through its own synchronizer, so the pulse counts per bank depend on where the request lands relative to both clocks. The bench runs the two clocks with a fixed phase offset. It drives shared requests only at instants that are edges of neither clock, which makes the number of surviving pulses in each bank an exact, computable figure. A per-output enable sweep then walks a single cleared bit across every output of both banks.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Default synchronizer depth for every request crossing into a domain.
    localparam int SYNC_DEPTH = 2;

    // Request bundle carried through each domain synchronizer.
    typedef struct packed {
        logic stop_n;   // domain stop request, active low
        logic pd_n;     // power-down request, active low
        logic hiz;      // three-state request, active high
    } ctl_req_t;

    localparam ctl_req_t CTL_IDLE = '{stop_n: 1'b1, pd_n: 1'b1, hiz: 1'b0};

    // A bank may run when not powered down and either not stopped or exempt from stop.
    function automatic logic may_run(ctl_req_t r, logic stop_exempt);
        return r.pd_n & (r.stop_n | stop_exempt);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] gclk_o,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    // Enables move on the falling edge, so they only change while clk is low.
    always_ff @(negedge clk) begin
        if (rst)        en_q <= '1;
        else if (run_i) en_q <= en_i;
        else            en_q <= '0;
    end

    for (genvar b = 0; b < N; b++) begin : g_and
        assign gclk_o[b] = clk & en_q[b];

        // R8: a gating enable never moves during the high phase
        always @(en_q[b]) begin
            p_en_low_phase_r8: assert (clk == 1'b0);
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int N_PCI       = 7,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk_cpu,
    input  logic             clk_pci,
    input  logic             rst,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pd_n,
    input  logic             hiz_req,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             pcif_en,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_CPU-1:0] cpu_oe_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic [N_PCI-1:0] pci_oe_o,
    output logic             pcif_clk_o,
    output logic             pcif_oe_o
);

    localparam int REQ_W = $bits(ctl_req_t);
    localparam int CPU_W = N_CPU + REQ_W;
    localparam int PCI_W = N_PCI + 1 + REQ_W;
    localparam logic [CPU_W-1:0] CPU_RST = {{N_CPU{1'b1}}, CTL_IDLE};
    localparam logic [PCI_W-1:0] PCI_RST = {{(N_PCI+1){1'b1}}, CTL_IDLE};

    // ---------------- processor domain ----------------
    ctl_req_t         cpu_req_d, cpu_req_s;
    logic [N_CPU-1:0] cpu_en_s, cpu_en_q;
    logic [CPU_W-1:0] cpu_q;

    assign cpu_req_d = '{stop_n: cpu_stop_n, pd_n: pd_n, hiz: hiz_req};

    clkstop_sync #(.W(CPU_W), .STAGES(SYNC_STAGES), .RST_VAL(CPU_RST)) u_cpu_sync (
        .clk (clk_cpu),
        .rst (rst),
        .d_i ({cpu_en, cpu_req_d}),
        .q_o (cpu_q)
    );
    assign {cpu_en_s, cpu_req_s} = cpu_q;

    clkstop_gate #(.N(N_CPU)) u_cpu_gate (
        .clk    (clk_cpu),
        .rst    (rst),
        .run_i  (may_run(cpu_req_s, 1'b0)),
        .en_i   (cpu_en_s),
        .gclk_o (cpu_clk_o),
        .en_o   (cpu_en_q)
    );
    assign cpu_oe_o = {N_CPU{~cpu_req_s.hiz}};

    // ---------------- bus domain ----------------
    ctl_req_t         pci_req_d, pci_req_s;
    logic [N_PCI-1:0] pci_en_s, pci_en_q;
    logic             pcif_en_s, pcif_en_q;
    logic [PCI_W-1:0] pci_q;

    assign pci_req_d = '{stop_n: pci_stop_n, pd_n: pd_n, hiz: hiz_req};

    clkstop_sync #(.W(PCI_W), .STAGES(SYNC_STAGES), .RST_VAL(PCI_RST)) u_pci_sync (
        .clk (clk_pci),
        .rst (rst),
        .d_i ({pcif_en, pci_en, pci_req_d}),
        .q_o (pci_q)
    );
    assign {pcif_en_s, pci_en_s, pci_req_s} = pci_q;

    clkstop_gate #(.N(N_PCI)) u_pci_gate (
        .clk    (clk_pci),
        .rst    (rst),
        .run_i  (may_run(pci_req_s, 1'b0)),
        .en_i   (pci_en_s),
        .gclk_o (pci_clk_o),
        .en_o   (pci_en_q)
    );

    // The free-running copy is exempt from the bus stop request.
    clkstop_gate #(.N(1)) u_pcif_gate (
        .clk    (clk_pci),
        .rst    (rst),
        .run_i  (may_run(pci_req_s, 1'b1)),
        .en_i   (pcif_en_s),
        .gclk_o (pcif_clk_o),
        .en_o   (pcif_en_q)
    );
    assign pci_oe_o  = {N_PCI{~pci_req_s.hiz}};
    assign pcif_oe_o = ~pci_req_s.hiz;

    // ---------------- assertions (two-stage latency form) ----------------
    if (SYNC_STAGES == 2) begin : g_chk
        // R2: a stop seen two edges ago has closed every processor gate
        p_cpu_stop_r2: assert property (@(posedge clk_cpu) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(cpu_stop_n, 2))
            |-> (cpu_en_q == '0));

        // R3: a clear request and full enables two edges ago open every gate
        p_cpu_resume_r3: assert property (@(posedge clk_cpu) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && $past(cpu_stop_n, 2)
             && $past(pd_n, 2) && ($past(cpu_en, 2) == '1))
            |-> (cpu_en_q == '1));

        // R4: bus stop closes the stoppable bus gates
        p_pci_stop_r4: assert property (@(posedge clk_pci) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(pci_stop_n, 2))
            |-> (pci_en_q == '0));

        // R4: the free-running copy stays open whatever the bus stop does
        p_pcif_free_r4: assert property (@(posedge clk_pci) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && $past(pd_n, 2) && $past(pcif_en, 2))
            |-> pcif_en_q);

        // R5: power-down closes the processor gates
        p_cpu_pd_r5: assert property (@(posedge clk_cpu) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(pd_n, 2))
            |-> (cpu_en_q == '0));

        // R5: power-down closes every bus gate, the free one included
        p_pci_pd_r5: assert property (@(posedge clk_pci) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(pd_n, 2))
            |-> ((pci_en_q == '0) && !pcif_en_q));

        // R7: pad enables follow the three-state request two edges later
        p_cpu_hiz_r7: assert property (@(posedge clk_cpu) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2))
            |-> (cpu_oe_o == {N_CPU{!$past(hiz_req, 2)}}));

        p_pci_hiz_r7: assert property (@(posedge clk_pci) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2))
            |-> ((pci_oe_o == {N_PCI{!$past(hiz_req, 2)}}) && (pcif_oe_o == !$past(hiz_req, 2))));
    end

endmodule

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;

    localparam int NC = 4;
    localparam int NP = 7;
    localparam int HC = 4;   // processor high phase, ns (125 MHz)
    localparam int HP = 8;   // bus high phase, ns

    logic clk_cpu = 1'b0;
    logic clk_pci = 1'b0;
    logic rst = 1'b1;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1, hiz_req = 1'b0;
    logic [NC-1:0] cpu_en = '1;
    logic [NP-1:0] pci_en = '1;
    logic pcif_en = 1'b1;
    logic [NC-1:0] cpu_clk_o, cpu_oe_o;
    logic [NP-1:0] pci_clk_o, pci_oe_o;
    logic pcif_clk_o, pcif_oe_o;

    always #4 clk_cpu = ~clk_cpu;
    initial begin
        #2;
        forever #8 clk_pci = ~clk_pci;
    end

    clkstop_ctrl #(.N_CPU(NC), .N_PCI(NP)) u_dut (
        .clk_cpu(clk_cpu), .clk_pci(clk_pci), .rst(rst),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pd_n(pd_n), .hiz_req(hiz_req),
        .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en),
        .cpu_clk_o(cpu_clk_o), .cpu_oe_o(cpu_oe_o),
        .pci_clk_o(pci_clk_o), .pci_oe_o(pci_oe_o),
        .pcif_clk_o(pcif_clk_o), .pcif_oe_o(pcif_oe_o)
    );

    int n_chk = 0, n_fail = 0, n_pulse = 0, n_runt = 0;
    bit mon_on = 1'b0, done = 1'b0;
    int cpu_cnt [NC];
    int pci_cnt [NP];
    int pcif_cnt = 0;
    int cb [NC];
    int pb [NP];
    int fb;

    initial begin
        for (int i = 0; i < NC; i++) cpu_cnt[i] = 0;
        for (int i = 0; i < NP; i++) pci_cnt[i] = 0;
    end

    // Pulse counters and full-phase monitors (R8)
    for (genvar i = 0; i < NC; i++) begin : g_cmon
        time tr = 0;
        always @(posedge cpu_clk_o[i]) if (mon_on) begin cpu_cnt[i]++; tr = $time; end
        always @(negedge cpu_clk_o[i]) if (mon_on && tr != 0) begin
            n_pulse++;
            if ($time - tr != HC) begin
                n_runt++;
                $display("FAIL R8 cpu out %0d high time actual=%0t expected=%0d", i, $time - tr, HC);
            end
        end
    end
    for (genvar i = 0; i < NP; i++) begin : g_pmon
        time tr = 0;
        always @(posedge pci_clk_o[i]) if (mon_on) begin pci_cnt[i]++; tr = $time; end
        always @(negedge pci_clk_o[i]) if (mon_on && tr != 0) begin
            n_pulse++;
            if ($time - tr != HP) begin
                n_runt++;
                $display("FAIL R8 pci out %0d high time actual=%0t expected=%0d", i, $time - tr, HP);
            end
        end
    end
    time ftr = 0;
    always @(posedge pcif_clk_o) if (mon_on) begin pcif_cnt++; ftr = $time; end
    always @(negedge pcif_clk_o) if (mon_on && ftr != 0) begin
        n_pulse++;
        if ($time - ftr != HP) begin
            n_runt++;
            $display("FAIL R8 free out high time actual=%0t expected=%0d", $time - ftr, HP);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        for (int i = 0; i < NC; i++) cb[i] = cpu_cnt[i];
        for (int i = 0; i < NP; i++) pb[i] = pci_cnt[i];
        fb = pcif_cnt;
    endtask

    task automatic wait_cpu(input int n);
        repeat (n) @(posedge clk_cpu);
        #1;
    endtask

    task automatic wait_pci(input int n);
        repeat (n) @(posedge clk_pci);
        #1;
    endtask

    task automatic chk_cpu(input string tag, input int exp);
        for (int i = 0; i < NC; i++) chk($sformatf("%s cpu%0d pulses", tag, i), cpu_cnt[i] - cb[i], exp);
    endtask

    task automatic chk_pci(input string tag, input int exp);
        for (int i = 0; i < NP; i++) chk($sformatf("%s pci%0d pulses", tag, i), pci_cnt[i] - pb[i], exp);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (6) @(posedge clk_pci);
        @(posedge clk_cpu); #2;
        rst = 1'b0;
        mon_on = 1'b1;
        wait_cpu(3);

        // R1: reset state, everything running and driven
        @(negedge clk_cpu); snap();
        wait_cpu(8);
        chk_cpu("R1", 8);
        chk("R1 cpu level high", int'(cpu_clk_o), (1 << NC) - 1);
        chk("R1 cpu oe", int'(cpu_oe_o), (1 << NC) - 1);
        @(negedge clk_pci); snap();
        wait_pci(8);
        chk_pci("R1", 8);
        chk("R1 free pulses", pcif_cnt - fb, 8);
        chk("R1 pci oe", int'({pcif_oe_o, pci_oe_o}), (1 << (NP + 1)) - 1);

        // R2: processor stop, two remaining pulses then low
        @(negedge clk_cpu); cpu_stop_n = 1'b0; snap();
        wait_cpu(2);
        chk_cpu("R2 early", 2);
        wait_cpu(6);
        chk_cpu("R2 held", 2);
        chk("R2 cpu level low", int'(cpu_clk_o), 0);
        chk("R2 cpu oe kept", int'(cpu_oe_o), (1 << NC) - 1);
        // R9: bus unaffected by processor stop
        @(negedge clk_pci); snap();
        wait_pci(4);
        chk_pci("R9 bus during cpu stop", 4);
        chk("R9 free during cpu stop", pcif_cnt - fb, 4);

        // R3: restart, first pulse at third edge
        @(negedge clk_cpu); cpu_stop_n = 1'b1; snap();
        wait_cpu(2);
        chk_cpu("R3 gap", 0);
        chk("R3 level before", int'(cpu_clk_o), 0);
        wait_cpu(1);
        chk_cpu("R3 first", 1);
        chk("R3 level after", int'(cpu_clk_o), (1 << NC) - 1);

        // R4: bus stop, free copy keeps running
        @(negedge clk_pci); pci_stop_n = 1'b0; snap();
        wait_pci(2);
        chk_pci("R4 early", 2);
        wait_pci(6);
        chk_pci("R4 held", 2);
        chk("R4 free runs", pcif_cnt - fb, 8);
        chk("R4 pci level low", int'(pci_clk_o), 0);
        chk("R4 free level high", int'(pcif_clk_o), 1);
        // R9: processor unaffected by bus stop
        @(negedge clk_cpu); snap();
        wait_cpu(4);
        chk_cpu("R9 cpu during bus stop", 4);
        @(negedge clk_pci); pci_stop_n = 1'b1; snap();
        wait_pci(2);
        chk_pci("R4 restart gap", 0);
        wait_pci(1);
        chk_pci("R4 restart first", 1);

        // R5: power-down across both domains
        @(negedge clk_pci); pd_n = 1'b0; snap();
        wait_pci(10);
        chk_cpu("R5 pd", 2);
        chk_pci("R5 pd", 2);
        chk("R5 pd free", pcif_cnt - fb, 2);
        chk("R5 pd oe", int'({pcif_oe_o, pci_oe_o, cpu_oe_o}), (1 << (NP + 1 + NC)) - 1);
        wait_cpu(1);
        chk("R5 pd cpu level", int'(cpu_clk_o), 0);
        @(negedge clk_pci); pd_n = 1'b1; snap();
        wait_pci(10);
        chk_cpu("R5 wake", 17);   // 19 processor edges in window, first two gapped
        chk_pci("R5 wake", 8);
        chk("R5 wake free", pcif_cnt - fb, 8);

        // R6: single cleared enable walked across processor outputs
        for (int k = 0; k < NC; k++) begin
            @(negedge clk_cpu); cpu_en = ~(NC'(1) << k); snap();
            wait_cpu(8);
            for (int i = 0; i < NC; i++)
                chk($sformatf("R6 cpu bit %0d out %0d", k, i), cpu_cnt[i] - cb[i], (i == k) ? 2 : 8);
            chk($sformatf("R6 cpu bit %0d level", k), int'(cpu_clk_o), ((1 << NC) - 1) & ~(1 << k));
            chk($sformatf("R6 cpu bit %0d oe", k), int'(cpu_oe_o), (1 << NC) - 1);
            @(negedge clk_cpu); cpu_en = '1;
            wait_cpu(4);
        end
        // R6: across stoppable bus outputs
        for (int k = 0; k < NP; k++) begin
            @(negedge clk_pci); pci_en = ~(NP'(1) << k); snap();
            wait_pci(8);
            for (int i = 0; i < NP; i++)
                chk($sformatf("R6 pci bit %0d out %0d", k, i), pci_cnt[i] - pb[i], (i == k) ? 2 : 8);
            chk($sformatf("R6 pci bit %0d free", k), pcif_cnt - fb, 8);
            chk($sformatf("R6 pci bit %0d level", k), int'(pci_clk_o), ((1 << NP) - 1) & ~(1 << k));
            @(negedge clk_pci); pci_en = '1;
            wait_pci(4);
        end
        // R6: free-running copy enable
        @(negedge clk_pci); pcif_en = 1'b0; snap();
        wait_pci(8);
        chk("R6 free disabled pulses", pcif_cnt - fb, 2);
        chk_pci("R6 bus with free off", 8);
        chk("R6 free level", int'(pcif_clk_o), 0);
        chk("R6 free oe", int'(pcif_oe_o), 1);
        @(negedge clk_pci); pcif_en = 1'b1;
        wait_pci(4);

        // R7: three-state request
        @(negedge clk_cpu); hiz_req = 1'b1;
        wait_cpu(1);
        chk("R7 cpu oe before", int'(cpu_oe_o), (1 << NC) - 1);
        wait_cpu(1);
        chk("R7 cpu oe off", int'(cpu_oe_o), 0);
        wait_pci(3);
        chk("R7 pci oe off", int'({pcif_oe_o, pci_oe_o}), 0);
        @(negedge clk_cpu); hiz_req = 1'b0;
        wait_cpu(2);
        chk("R7 cpu oe back", int'(cpu_oe_o), (1 << NC) - 1);
        wait_pci(3);
        chk("R7 pci oe back", int'({pcif_oe_o, pci_oe_o}), (1 << (NP + 1)) - 1);

        // R8: no truncated pulse seen anywhere
        wait_cpu(4);
        chk("R8 runt pulses", n_runt, 0);
        chk("R8 pulses observed", int'(n_pulse > 0), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_cpu);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule